// File: doc/BRIEF.md
# DMA Channel Register Bank with Start Gating

This block holds the programming registers for a set of DMA channels and decides when a channel transfer is launched. Each channel has three 32-bit registers in its own 16-byte slot: a memory address, a block count/size word and a control word. A single shared enable register holds one enable bit per channel. Software writes these registers over a simple write strobe and address bus. Reads are combinational and return the stored values.

A write to a channel's control word stores the new value. If that new word has its start bit set and the channel's enable bit is set, the block sends out a one-cycle start request. The request carries the channel number, the channel's address and count registers and the freshly written control word. A downstream transfer engine consumes the request. When that engine finishes, it pulses a per-channel done input, which clears the start bit again. One channel slot is reserved: it holds no registers, and writes to it are dropped.

Top module: `dma_start_gate`

## Requirements
- R1: After reset every channel register and the enable register read 0, and `start_valid` and `restart_seen` are 0.
- R2: Channel n's slot starts at byte offset 0x1080 + 16·n. The address register is at +0 and the count register at +4. Writing either stores the full 32-bit word, reads back unchanged, and produces no start request.
- R3: A write to channel n's control word (+8) stores it. If bit 24 of the written word is 1 and bit (4·n + 3) of the enable register is 1, `start_valid` is 1 in the cycle after the write and `start_chan` equals n.
- R4: A control-word write whose bit 24 is 0, or whose channel enable bit is 0, stores the word but raises no start request.
- R5: With a start request, `start_madr` and `start_bcr` carry the channel's stored address and count registers, and `start_chcr` carries the control word just written.
- R6: Channel 5 is not implemented. Its offsets read 0, writes to them change no register, and they never produce a start request.
- R7: `restart_seen` pulses in the cycle after a control-word write whose bit 24 is 1 while the stored control word already had bit 24 set. This is independent of the enable bit.
- R8: A 1 on `xfer_done[n]` clears bit 24 of channel n's control word and leaves every other bit. If a control-word write to that channel occurs in the same cycle, the written value is kept.
- R9: The enable register is at offset 0x10F0 and stores and returns a full 32-bit word.
- R10: Offsets that map to no register read 0, and writes to them have no effect. This covers +0xC in a channel slot, addresses whose low two bits are not 0, and offsets outside the bank.
- R11: `start_valid` and `restart_seen` are single-cycle pulses. Each falls in the cycle after a write unless another qualifying write follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 16 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| xfer_done | input | 7 | Per-channel completion pulse; clears the start bit |
| start_valid | output | 1 | One-cycle start request |
| start_chan | output | 3 | Channel number of the request |
| start_madr | output | 32 | Address register of the started channel |
| start_bcr | output | 32 | Count register of the started channel |
| start_chcr | output | 32 | Control word that caused the start |
| restart_seen | output | 1 | One-cycle flag: start bit rewritten while already set |

## Verification
The checker assumes a request pulse can only follow a write strobe in the previous cycle. It also assumes writes arrive at most one per cycle, so a high `start_valid` in two successive cycles always has a write behind each. The stimulus drives every write strobe for exactly one cycle. Addresses are drawn from all eight 16-byte slots, including the reserved channel, the enable slot and the unused +0xC offset, and some addresses have nonzero low bits. Done pulses are random, and one is placed deliberately on the same cycle as a control write.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

   localparam int CH_IDX_W = 3;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic                hit_ch;
      logic                hit_pcr;
      logic [CH_IDX_W-1:0] ch;
      reg_sel_e            sel;
   } dec_t;

endpackage

// File: rtl/dma_gate_decode.sv
module dma_gate_decode
   import dma_gate_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int BASE     = 'h1080,
   parameter int PCR_OFF  = 'h10F0,
   parameter int NUM_CH   = 7,
   parameter int SKIP_CH  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE + NUM_CH * 16);
   localparam logic [ADDR_W-1:0] PCR_A  = ADDR_W'(PCR_OFF);

   logic [ADDR_W-1:0] off;
   logic              in_win;
   logic              aligned;
   logic              off_unused;

   always_comb begin
      off        = addr - BASE_A;
      off_unused = ^off;
      in_win     = (addr >= BASE_A) && (addr < END_A);
      aligned    = (addr[1:0] == 2'b00);
      dec.ch     = off[4 +: CH_IDX_W];
      dec.sel    = reg_sel_e'(off[3:2]);
      dec.hit_ch = in_win && aligned && (dec.sel != SEL_NONE) &&
                   (dec.ch != CH_IDX_W'(SKIP_CH));
      dec.hit_pcr = (addr == PCR_A);
   end
endmodule

// File: rtl/dma_gate_chan.sv
module dma_gate_chan #(
   parameter int DATA_W    = 32,
   parameter int START_BIT = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_madr,
   input  logic              we_bcr,
   input  logic              we_chcr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done,
   output logic [DATA_W-1:0] madr,
   output logic [DATA_W-1:0] bcr,
   output logic [DATA_W-1:0] chcr
);
   localparam logic [DATA_W-1:0] START_MASK = DATA_W'(1) << START_BIT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         madr <= '0;
         bcr  <= '0;
         chcr <= '0;
      end else begin
         if (we_madr) madr <= wdata;
         if (we_bcr)  bcr  <= wdata;
         if (we_chcr)   chcr <= wdata;
         else if (done) chcr <= chcr & ~START_MASK;
      end
   end
endmodule

// File: rtl/dma_gate_launch.sv
module dma_gate_launch #(
   parameter int DATA_W = 32,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              again,
   input  logic [CH_W-1:0]   chan,
   input  logic [DATA_W-1:0] madr,
   input  logic [DATA_W-1:0] bcr,
   input  logic [DATA_W-1:0] chcr,
   output logic              req_valid,
   output logic [CH_W-1:0]   req_chan,
   output logic [DATA_W-1:0] req_madr,
   output logic [DATA_W-1:0] req_bcr,
   output logic [DATA_W-1:0] req_chcr,
   output logic              req_again
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_again <= 1'b0;
         req_chan  <= '0;
         req_madr  <= '0;
         req_bcr   <= '0;
         req_chcr  <= '0;
      end else begin
         req_valid <= fire;
         req_again <= again;
         if (fire) begin
            req_chan <= chan;
            req_madr <= madr;
            req_bcr  <= bcr;
            req_chcr <= chcr;
         end
      end
   end
endmodule

// File: rtl/dma_start_gate.sv
module dma_start_gate
   import dma_gate_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int NUM_CH    = 7,
   parameter int SKIP_CH   = 5,
   parameter int START_BIT = 24,
   parameter int BASE      = 'h1080,
   parameter int PCR_OFF   = 'h10F0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_CH-1:0]   xfer_done,
   output logic                start_valid,
   output logic [CH_IDX_W-1:0] start_chan,
   output logic [DATA_W-1:0]   start_madr,
   output logic [DATA_W-1:0]   start_bcr,
   output logic [DATA_W-1:0]   start_chcr,
   output logic                restart_seen
);
   localparam int SLOTS = 1 << CH_IDX_W;

   if (NUM_CH > SLOTS) begin : g_bad_count
      $error("NUM_CH exceeds the channel index range");
   end
   if (DATA_W < 4 * NUM_CH) begin : g_bad_width
      $error("DATA_W too narrow for one enable nibble per channel");
   end
   if (START_BIT >= DATA_W) begin : g_bad_start
      $error("START_BIT outside the data word");
   end
   if (PCR_OFF < BASE + NUM_CH * 16) begin : g_bad_pcr
      $error("enable register overlaps the channel window");
   end

   dec_t              dec;
   logic [DATA_W-1:0] pcr_q;
   logic [DATA_W-1:0] madr_q [SLOTS];
   logic [DATA_W-1:0] bcr_q  [SLOTS];
   logic [DATA_W-1:0] chcr_q [SLOTS];
   logic [SLOTS-1:0]  en_vec;
   logic              ctrl_wr;
   logic              fire;
   logic              again;

   dma_gate_decode #(
      .ADDR_W (ADDR_W), .BASE (BASE), .PCR_OFF (PCR_OFF),
      .NUM_CH (NUM_CH), .SKIP_CH (SKIP_CH)
   ) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                    pcr_q <= '0;
      else if (bus_wr && dec.hit_pcr) pcr_q <= bus_wdata;
   end

   for (genvar i = 0; i < SLOTS; i++) begin : g_ch
      if (i < NUM_CH && i != SKIP_CH) begin : g_live
         logic sel_me;
         assign sel_me    = bus_wr && dec.hit_ch && (dec.ch == CH_IDX_W'(i));
         assign en_vec[i] = pcr_q[4*i + 3];
         dma_gate_chan #(.DATA_W (DATA_W), .START_BIT (START_BIT)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_madr (sel_me && dec.sel == SEL_ADDR),
            .we_bcr  (sel_me && dec.sel == SEL_COUNT),
            .we_chcr (sel_me && dec.sel == SEL_CTRL),
            .wdata   (bus_wdata),
            .done    (xfer_done[i]),
            .madr    (madr_q[i]),
            .bcr     (bcr_q[i]),
            .chcr    (chcr_q[i])
         );
      end else begin : g_hole
         assign en_vec[i] = 1'b0;
         assign madr_q[i] = '0;
         assign bcr_q[i]  = '0;
         assign chcr_q[i] = '0;
      end
   end

   if (SKIP_CH < NUM_CH) begin : g_skip_done
      logic done_unused;
      assign done_unused = xfer_done[SKIP_CH];
   end

   always_comb begin
      ctrl_wr = bus_wr && dec.hit_ch && (dec.sel == SEL_CTRL);
      fire    = ctrl_wr && bus_wdata[START_BIT] && en_vec[dec.ch];
      again   = ctrl_wr && bus_wdata[START_BIT] && chcr_q[dec.ch][START_BIT];
   end

   always_comb begin
      bus_rdata = '0;
      if (dec.hit_ch) begin
         unique case (dec.sel)
            SEL_ADDR:  bus_rdata = madr_q[dec.ch];
            SEL_COUNT: bus_rdata = bcr_q[dec.ch];
            SEL_CTRL:  bus_rdata = chcr_q[dec.ch];
            default:   bus_rdata = '0;
         endcase
      end else if (dec.hit_pcr) begin
         bus_rdata = pcr_q;
      end
   end

   dma_gate_launch #(.DATA_W (DATA_W), .CH_W (CH_IDX_W)) u_launch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .again     (again),
      .chan      (dec.ch),
      .madr      (madr_q[dec.ch]),
      .bcr       (bcr_q[dec.ch]),
      .chcr      (bus_wdata),
      .req_valid (start_valid),
      .req_chan  (start_chan),
      .req_madr  (start_madr),
      .req_bcr   (start_bcr),
      .req_chcr  (start_chcr),
      .req_again (restart_seen)
   );
endmodule

// File: rtl/dma_start_gate_chk.sv
module dma_start_gate_chk #(
   parameter int DATA_W    = 32,
   parameter int NUM_CH    = 7,
   parameter int SKIP_CH   = 5,
   parameter int START_BIT = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              start_valid,
   input logic [2:0]        start_chan,
   input logic [DATA_W-1:0] start_chcr,
   input logic              restart_seen
);
   a_r3_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> $past(bus_wr));

   a_r4_start_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> start_chcr[START_BIT]);

   a_r6_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> (start_chan != 3'(SKIP_CH)));

   a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> (32'(start_chan) < NUM_CH));

   a_r7_restart_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      restart_seen |-> $past(bus_wr));

   a_r11_pulse_drops: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |=> (!start_valid || $past(bus_wr)));
endmodule

bind dma_start_gate dma_start_gate_chk #(
   .DATA_W (DATA_W), .NUM_CH (NUM_CH), .SKIP_CH (SKIP_CH), .START_BIT (START_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .start_valid  (start_valid),
   .start_chan   (start_chan),
   .start_chcr   (start_chcr),
   .restart_seen (restart_seen)
);

// File: tb/dma_start_gate_tb.sv
module dma_start_gate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  xfer_done = '0;
   logic        start_valid;
   logic [2:0]  start_chan;
   logic [31:0] start_madr, start_bcr, start_chcr;
   logic        restart_seen;

   int n_checks = 0;
   int n_fail   = 0;

   logic [31:0] m_madr [8];
   logic [31:0] m_bcr  [8];
   logic [31:0] m_chcr [8];
   logic [31:0] m_pcr;

   always #10 clk = ~clk;

   dma_start_gate u_dut (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .xfer_done (xfer_done),
      .start_valid (start_valid), .start_chan (start_chan),
      .start_madr (start_madr), .start_bcr (start_bcr), .start_chcr (start_chcr),
      .restart_seen (restart_seen)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // returns slot kind: 0 none, 1 addr, 2 count, 3 ctrl, 4 enable register
   function automatic int kind_of(input logic [15:0] a, output int ch);
      int off;
      ch = 0;
      if (a == 16'h10F0) return 4;
      if (a < 16'h1080 || a >= 16'h10F0 || a[1:0] != 2'b00) return 0;
      off = int'(a) - 'h1080;
      ch  = off / 16;
      if (ch == 5 || (off % 16) == 12) return 0;
      return (off % 16) / 4 + 1;
   endfunction

   function automatic logic [31:0] exp_read(input logic [15:0] a);
      int ch;
      case (kind_of(a, ch))
         1: return m_madr[ch];
         2: return m_bcr[ch];
         3: return m_chcr[ch];
         4: return m_pcr;
         default: return 32'h0;
      endcase
   endfunction

   task automatic do_read(input logic [15:0] a, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp_read(a));
   endtask

   task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                           input logic [6:0] dn, input string tag);
      int ch, k;
      logic e_fire, e_again;
      logic [31:0] e_madr, e_bcr;
      k = kind_of(a, ch);
      e_fire  = (k == 3) && d[24] && m_pcr[4*ch + 3];
      e_again = (k == 3) && d[24] && m_chcr[ch][24];
      e_madr  = m_madr[ch];
      e_bcr   = m_bcr[ch];
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; xfer_done = dn;
      @(posedge clk);
      #1;
      for (int i = 0; i < 7; i++)
         if (dn[i] && i != 5) m_chcr[i][24] = 1'b0;
      case (k)
         1: m_madr[ch] = d;
         2: m_bcr[ch]  = d;
         3: m_chcr[ch] = d;
         4: m_pcr      = d;
         default: ;
      endcase
      chk({tag, " R3 start_valid"}, 32'(start_valid), 32'(e_fire));
      chk({tag, " R7 restart_seen"}, 32'(restart_seen), 32'(e_again));
      if (e_fire) begin
         chk({tag, " R3 start_chan"}, 32'(start_chan), 32'(ch));
         chk({tag, " R5 start_madr"}, start_madr, e_madr);
         chk({tag, " R5 start_bcr"}, start_bcr, e_bcr);
         chk({tag, " R5 start_chcr"}, start_chcr, d);
      end
      @(negedge clk);
      bus_wr = 1'b0; xfer_done = '0;
      @(posedge clk);
      #1;
      chk({tag, " R11 pulse ends"}, 32'(start_valid), 32'h0);
      chk({tag, " R11 restart ends"}, 32'(restart_seen), 32'h0);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      int seed = 32'h5EED_1234;
      void'($urandom(seed));
      for (int i = 0; i < 8; i++) begin
         m_madr[i] = '0; m_bcr[i] = '0; m_chcr[i] = '0;
      end
      m_pcr = '0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      chk("R1 start_valid after reset", 32'(start_valid), 32'h0);
      chk("R1 restart after reset", 32'(restart_seen), 32'h0);
      for (int c = 0; c < 8; c++)
         for (int r = 0; r < 4; r++)
            do_read(16'(16'h1080 + c * 16 + r * 4), "R1 reset readback");

      // directed corners
      do_write(16'h10A0, 32'h0010_0000, '0, "R2 addr ch2");
      do_write(16'h10A4, 32'h0001_0010, '0, "R2 count ch2");
      do_read(16'h10A0, "R2 addr readback");
      do_read(16'h10A4, "R2 count readback");
      do_write(16'h10A8, 32'h0100_0201, '0, "R4 ctrl no enable");
      do_write(16'h10F0, 32'h0000_0800, '0, "R9 enable ch2");
      do_read(16'h10F0, "R9 enable readback");
      do_write(16'h10A8, 32'h0100_0201, '0, "R3 R7 start ch2 restart");
      do_write(16'h10A8, 32'h0000_0201, '0, "R4 ctrl bit clear");
      do_write(16'h10A8, 32'h0100_0001, '0, "R3 start ch2 again");
      do_write(16'h1000, 32'h0, 7'b000_0100, "R8 done ch2");
      do_read(16'h10A8, "R8 start bit cleared");
      do_write(16'h10F0, 32'h0FFF_FFFF, '0, "R9 enable all");
      do_write(16'h10D8, 32'h0100_0000, '0, "R6 reserved ctrl");
      do_write(16'h10D0, 32'h1234_5678, '0, "R6 reserved addr");
      do_read(16'h10D0, "R6 reserved reads zero");
      do_read(16'h10D8, "R6 reserved ctrl reads zero");
      do_write(16'h10EC, 32'hDEAD_BEEF, '0, "R10 slot gap");
      do_read(16'h10EC, "R10 gap reads zero");
      do_write(16'h1089, 32'h0100_0000, '0, "R10 misaligned");
      do_read(16'h1088, "R10 misaligned no store");
      do_write(16'h10E8, 32'h0100_0000, 7'b100_0000, "R8 done with write ch6");
      do_read(16'h10E8, "R8 write wins over done");

      // random mix
      for (int it = 0; it < 500; it++) begin
         int c, r;
         logic [15:0] a;
         logic [31:0] d;
         logic [6:0]  dn;
         c = int'($urandom % 8);
         r = int'($urandom % 4);
         a = 16'(16'h1080 + c * 16 + r * 4);
         if ($urandom % 10 == 0) a = a + 16'($urandom % 4);
         if ($urandom % 12 == 0) a = 16'($urandom);
         d = $urandom;
         d[24] = ($urandom % 2 == 0);
         dn = ($urandom % 4 == 0) ? 7'($urandom) : 7'h0;
         do_write(a, d, dn, "R3 R4 R5 R8 random");
         do_read(16'(16'h1080 + int'($urandom % 8) * 16 + int'($urandom % 4) * 4),
                 "R2 R9 R10 random read");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule